// File: doc/BRIEF.md
# Write Precompensation Pulse Shifter

This block sits between a floppy disk controller and the drive's write circuitry. Each write-data strobe from the controller becomes one output pulse, sent early, on time or late by one step of the 8 MHz clock (125 ns). Shifting the pulse this way counters the peak shift that magnetic media introduce when adjacent flux transitions crowd each other. The controller picks the shift with two select lines. A mode input forces the shift off during single-density (FM) recording.

The strobe is sampled on the local clock, and only its rising edge counts. That edge preloads a small up-counter with one of three start values. The counter runs up through the pulse window and wraps to an idle value of all zeros, where it stays. The output is high while the counter sits in the two states just below wrap. The delay therefore changes in whole clock steps, and the pulse is always two clocks wide.

Top module: `write_precomp_shifter`

## Requirements
- R1: A synchronous reset returns the counter to idle (all zeros) and drives `wpulse_o` low on the cycle after it is seen, even when a pulse is in progress.
- R2: With `mfm_i`=1, `early_i`=0 and `late_i`=0 (no shift), `wpulse_o` first goes high one clock after the clock edge that detects a strobe rise. At that edge the counter loads 1101.
- R3: With `mfm_i`=1, `early_i`=1 and `late_i`=0 (early), `wpulse_o` is high starting from the edge that detects the strobe rise, a delay of 0 clocks. The counter loads 1110.
- R4: With `mfm_i`=1, `early_i`=0 and `late_i`=1 (late), `wpulse_o` first goes high two clocks after the detecting edge. The counter loads 1100.
- R5: The unused select code `early_i`=1, `late_i`=1 behaves as no shift, a delay of 1 clock.
- R6: With `mfm_i`=0 (FM), the delay is 1 clock whatever the select lines say.
- R7: Every output pulse is high for exactly two consecutive clocks, which are the counter states 1110 and 1111.
- R8: After 1111 the counter wraps to 0000 and holds there. One strobe yields exactly one pulse, and the output stays low until the next strobe rise.
- R9: A strobe is detected only when `wstrobe_i` is high at a clock edge and was low at the previous edge. A strobe held high for several clocks neither reloads the counter nor produces a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz counter clock |
| rst | input | 1 | Synchronous reset, active high |
| wstrobe_i | input | 1 | Write-data strobe from the controller |
| early_i | input | 1 | Shift select line: request early |
| late_i | input | 1 | Shift select line: request late |
| mfm_i | input | 1 | 1 = double-density (shift allowed), 0 = FM (no shift) |
| wpulse_o | output | 1 | Shifted write pulse, two clocks wide |

## Verification
The hardest conditions to reach from the ports are the ones that sit on top of a running pulse. One is a strobe held high long enough to span the counter's wrap. The other is a reset that arrives while the output is high. The bench sweeps every mode and select combination with both a one-clock strobe and a strobe held for six clocks, and it samples the output for ten clocks after each rise. A held strobe still being high after the wrap would expose a reload or a second pulse. A separate pass launches an early pulse, asserts reset in its first high cycle, and checks that the output drops and the next strobe behaves normally.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    SHIFT_NONE  = 2'd0,
    SHIFT_EARLY = 2'd1,
    SHIFT_LATE  = 2'd2
  } shift_e;

  // Map mode and select lines to a shift choice.
  function automatic shift_e decode_shift(input logic mfm, input logic early, input logic late);
    shift_e s;
    if (!mfm)                s = SHIFT_NONE;   // FM: never shifted
    else if (early && !late) s = SHIFT_EARLY;
    else if (late && !early) s = SHIFT_LATE;
    else                     s = SHIFT_NONE;   // both or neither
    return s;
  endfunction

  // Clocks from load to first high output for a shift choice.
  function automatic int unsigned shift_delay(input shift_e s);
    int unsigned d;
    case (s)
      SHIFT_EARLY: d = 0;
      SHIFT_LATE:  d = 2;
      default:     d = 1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/wpc_edge_detect.sv
module wpc_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b0;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/wpc_start_select.sv
module wpc_start_select
  import wpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             mfm_i,
  input  logic             early_i,
  input  logic             late_i,
  output logic [CNT_W-1:0] start_o,
  output shift_e           shift_o
);
  // First pulse state: all ones except bit 0.
  localparam logic [CNT_W-1:0] PULSE_START = {{(CNT_W-1){1'b1}}, 1'b0};

  function automatic logic [CNT_W-1:0] start_for(input shift_e s);
    return PULSE_START - CNT_W'(shift_delay(s));
  endfunction

  always_comb begin
    shift_o = decode_shift(mfm_i, early_i, late_i);
    start_o = start_for(shift_o);
  end
endmodule

// File: rtl/wpc_counter.sv
module wpc_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] IDLE = '0;

  logic [CNT_W-1:0] count_q;
  logic             running;

  assign running = (count_q != IDLE);

  always_ff @(posedge clk) begin
    if (rst)          count_q <= IDLE;
    else if (load_i)  count_q <= load_val_i;
    else if (running) count_q <= count_q + 1'b1;  // wraps to IDLE, then holds
  end

  // High in the top two states only (bit 1 over the reachable states).
  assign pulse_o = &count_q[CNT_W-1:1];
  assign count_o = count_q;
endmodule

// File: rtl/write_precomp_shifter.sv
module write_precomp_shifter
  import wpc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wstrobe_i,
  input  logic early_i,
  input  logic late_i,
  input  logic mfm_i,
  output logic wpulse_o
);
  logic             strobe_rise;
  logic [CNT_W-1:0] load_value;
  logic [CNT_W-1:0] count_q;
  shift_e           shift_sel;

  wpc_edge_detect u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (wstrobe_i),
    .rise_o  (strobe_rise)
  );

  wpc_start_select #(.CNT_W(CNT_W)) u_sel (
    .mfm_i   (mfm_i),
    .early_i (early_i),
    .late_i  (late_i),
    .start_o (load_value),
    .shift_o (shift_sel)
  );

  wpc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (strobe_rise),
    .load_val_i (load_value),
    .count_o    (count_q),
    .pulse_o    (wpulse_o)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             wstrobe_i,
  input logic             early_i,
  input logic             late_i,
  input logic             mfm_i,
  input logic             strobe_rise,
  input logic [CNT_W-1:0] count_q,
  input logic             wpulse_o
);
  localparam logic [CNT_W-1:0] TOP_M1 = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] NORMAL = TOP_M1 - 1'b1;
  localparam logic [CNT_W-1:0] LATE   = TOP_M1 - 2'd2;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (count_q == '0) && !wpulse_o);

  assert_normal_load_R2: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && mfm_i && (early_i == late_i)) |=> (count_q == NORMAL) && !wpulse_o);

  assert_early_now_R3: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && mfm_i && early_i && !late_i) |=> wpulse_o);

  assert_late_load_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && mfm_i && late_i && !early_i) |=> (count_q == LATE) && !wpulse_o);

  assert_fm_unshifted_R6: assert property (@(posedge clk) disable iff (rst)
    (strobe_rise && !mfm_i) |=> (count_q == NORMAL));

  assert_pulse_min_width_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(wpulse_o) && !strobe_rise) |=> wpulse_o);

  assert_pulse_max_width_R7: assert property (@(posedge clk) disable iff (rst)
    (wpulse_o && $past(wpulse_o) && !strobe_rise) |=> !wpulse_o);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    ((count_q == '0) && !strobe_rise) |=> (count_q == '0) && !wpulse_o);

  assert_no_reload_held_R9: assert property (@(posedge clk) disable iff (rst)
    (wstrobe_i && $past(wstrobe_i) && !$past(rst)) |-> !strobe_rise);
endmodule

bind write_precomp_shifter wpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wstrobe_i   (wstrobe_i),
  .early_i     (early_i),
  .late_i      (late_i),
  .mfm_i       (mfm_i),
  .strobe_rise (strobe_rise),
  .count_q     (count_q),
  .wpulse_o    (wpulse_o)
);

// File: tb/write_precomp_shifter_tb.sv
module write_precomp_shifter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wstrobe_i = 1'b0;
  logic early_i = 1'b0;
  logic late_i = 1'b0;
  logic mfm_i = 1'b0;
  logic wpulse_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  write_precomp_shifter #(.CNT_W(4)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .wstrobe_i (wstrobe_i),
    .early_i   (early_i),
    .late_i    (late_i),
    .mfm_i     (mfm_i),
    .wpulse_o  (wpulse_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: wpulse_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Delay in clocks computed from the requirements.
  function automatic int exp_delay(input logic m, input logic e, input logic l);
    if (m && e && !l) return 0;   // R3
    if (m && l && !e) return 2;   // R4
    return 1;                     // R2, R5, R6
  endfunction

  function automatic string delay_tag(input logic m, input logic e, input logic l);
    if (!m)    return "R6";
    if (e && l) return "R5";
    if (e)     return "R3";
    if (l)     return "R4";
    return "R2";
  endfunction

  task automatic run_case(input logic m, input logic e, input logic l, input int hold);
    int d;
    d = exp_delay(m, e, l);
    @(negedge clk);
    mfm_i = m; early_i = e; late_i = l; wstrobe_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i < d)          check(delay_tag(m, e, l), wpulse_o, 1'b0);
      else if (i == d)    check(delay_tag(m, e, l), wpulse_o, 1'b1);
      else if (i == d + 1) check("R7", wpulse_o, 1'b1);
      else if (hold > 1 && i < hold) check("R9", wpulse_o, 1'b0);
      else                check("R8", wpulse_o, 1'b0);
      if (i + 1 == hold) wstrobe_i = 1'b0;
    end
    wstrobe_i = 1'b0;
    @(negedge clk);
    check("R8", wpulse_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", wpulse_o, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", wpulse_o, 1'b0);

    for (int h = 0; h < 2; h++)
      for (int c = 0; c < 8; c++)
        run_case(c[2], c[1], c[0], (h == 0) ? 1 : 6);

    // Reset during a pulse (R1)
    @(negedge clk);
    mfm_i = 1'b1; early_i = 1'b1; late_i = 1'b0; wstrobe_i = 1'b1;
    @(negedge clk);
    check("R3", wpulse_o, 1'b1);
    wstrobe_i = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1", wpulse_o, 1'b0);
    @(negedge clk);
    check("R1", wpulse_o, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", wpulse_o, 1'b0);
    end
    run_case(1'b1, 1'b0, 1'b1, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule